// File: doc/BRIEF.md
# Brick Stage Sequencer

This block is the central controller of a brick-based volume processor. The output volume is cut into bricks, and each brick passes through four stages in strict order. First its parameters are formed. Then its input region is fetched into an input cache. Then the compute pipelines process it. Finally the finished brick is written out to memory. The sequencer keeps different bricks in different stages at the same time, so the stages work as a system-level pipeline and the slowest stage sets the rate.

A host programs a ten-word register file. The words hold the brick count, a base and a per-brick step for the input origin and for the output origin, the input and output brick sizes, a projection angle, a user tag and the control bits. The sequencer then issues commands to three subsystems over valid/ready handshakes. Each subsystem reports completion with a one-cycle done pulse.

Two hazards shape the issue rules:
- The input cache has two sections used in ping-pong fashion, so a brick can only be fetched into a section the compute stage has released.
- The output store has two caches. One fills while the other drains, so compute on a brick can only start when one of the two output caches is free.

Top module: `brk_stage_seq`

## Requirements
- R1: After reset, all three command valids are low, the done flag is low, all stage busy flags are low and the stored-brick count is zero.
- R2: Register map (word address on `reg_addr`):
  - 0: control. Bit 0 is start and bit 1 is stop.
  - 1: brick count.
  - 2 and 3: input origin base and step.
  - 4: input size.
  - 5 and 6: output origin base and step.
  - 7: output size.
  - 8: angle.
  - 9: tag.
  - For brick n, the fetch origin is base2 + n*step3 and the store origin is base5 + n*step6, both modulo 2^32. The compute command carries n, the angle and the tag. Writes to addresses 10 to 15 have no effect.
- R3: For every brick, compute is issued only after its fetch done pulse and store only after its compute done pulse. Each stage handles bricks in ascending index order.
- R4: Each stage has at most one command outstanding. It issues its next command only after the done pulse for the previous one.
- R5: A fetch is not issued while two bricks hold input sections. A brick holds a section from its fetch issue until its compute done. The section of brick n is bit 0 of n.
- R6: A compute is not issued while two bricks hold output caches. A brick holds a cache from its compute issue until its store done. The cache of brick n is bit 0 of n, on both the compute and the store command.
- R7: Different stages are busy on different bricks at the same time.
- R8: When a run ends, `run_done` rises. A run ends once every brick whose parameters were formed has been stored, and either the brick count was reached or stop is set. With a brick count of zero, the run ends with no command issued.
- R9: While stop is set, no further brick enters the parameter stage. Bricks already in flight complete and are stored.
- R10: `stage_busy` shows, in bits 0 to 3, a brick waiting in the parameter mailbox and an outstanding fetch, compute and store. `bricks_stored` counts store done pulses in the current run.
- R11: A start written while a run is active has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| fetch_valid | output | 1 | Fetch command valid |
| fetch_ready | input | 1 | Fetch command accepted |
| fetch_origin | output | 32 | Input brick origin |
| fetch_size | output | 32 | Input brick size |
| fetch_sect | output | 1 | Input section to fill |
| fetch_done | input | 1 | Fetch completion pulse |
| comp_valid | output | 1 | Compute command valid |
| comp_ready | input | 1 | Compute command accepted |
| comp_brick | output | 16 | Brick index |
| comp_angle | output | 32 | Projection angle |
| comp_tag | output | 32 | User tag |
| comp_sect | output | 1 | Input section to read |
| comp_ocache | output | 1 | Output cache to fill |
| comp_done | input | 1 | Compute completion pulse |
| store_valid | output | 1 | Store command valid |
| store_ready | input | 1 | Store command accepted |
| store_origin | output | 32 | Output brick origin |
| store_size | output | 32 | Output brick size |
| store_ocache | output | 1 | Output cache to drain |
| store_done | input | 1 | Store completion pulse |
| run_busy | output | 1 | Run active |
| run_done | output | 1 | Run finished (sticky until next start) |
| stage_busy | output | 4 | Per-stage busy flags |
| bricks_stored | output | 16 | Bricks stored this run |

## Verification
The assertions take for granted three things about the inputs:
- a subsystem pulses its done line only while it holds an accepted command;
- the host leaves the brick count and origin registers alone during a run;
- the brick count fits in 16 bits.

The bench's responders follow these rules. Each raises done exactly once, a random one or more cycles after an accept. The bench writes only the control word while a run is active, and it keeps brick counts small. Random ready patterns and skewed per-stage latencies push the two ping-pong limits to their bound without stepping outside these assumptions.

// File: rtl/brk_seq_pkg.sv
// Shared constants and types for the brick stage sequencer.
// Assumes a 32-bit host register file with ten words.
package brk_seq_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int NREG      = 10;
    localparam int LEAD_MAX  = 2;   // ping-pong depth of input sections and output caches
    localparam int START_BIT = 0;
    localparam int STOP_BIT  = 1;

    localparam logic [ADDR_W-1:0] REG_CTRL = 4'd0;

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] in_base;
        logic [DATA_W-1:0] in_step;
        logic [DATA_W-1:0] in_size;
        logic [DATA_W-1:0] out_base;
        logic [DATA_W-1:0] out_step;
        logic [DATA_W-1:0] out_size;
        logic [DATA_W-1:0] angle;
        logic [DATA_W-1:0] tag;
    } cfg_t;
endpackage

// File: rtl/brk_param_regs.sv
// Host register file. Word 0 holds the stop bit and decodes a start pulse;
// words 1..NREG-1 hold run parameters. Higher addresses are ignored.
module brk_param_regs
    import brk_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              start_pulse,
    output logic              stop_q,
    output cfg_t              cfg
);
    logic [DATA_W-1:0] bank [1:NREG-1];

    // Capture host writes; control word keeps only the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            for (int i = 1; i < NREG; i++) bank[i] <= '0;
        end else if (we) begin
            if (addr == REG_CTRL) stop_q <= wdata[STOP_BIT];
            for (int i = 1; i < NREG; i++)
                if (addr == ADDR_W'(i)) bank[i] <= wdata;
        end
    end

    // Start is a write-time pulse, not a stored bit.
    always_comb start_pulse = we && (addr == REG_CTRL) && wdata[START_BIT];

    // Present the stored words as a typed bundle.
    always_comb begin
        cfg.count    = bank[1];
        cfg.in_base  = bank[2];
        cfg.in_step  = bank[3];
        cfg.in_size  = bank[4];
        cfg.out_base = bank[5];
        cfg.out_step = bank[6];
        cfg.out_size = bank[7];
        cfg.angle    = bank[8];
        cfg.tag      = bank[9];
    end
endmodule

// File: rtl/brk_stage_trk.sv
// Tracks one stage: counts issued commands and completion pulses.
// Assumes the subsystem pulses done only while a command is outstanding.
module brk_stage_trk #(
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          issue,
    input  logic          done,
    output logic [BW-1:0] iss_cnt,
    output logic [BW-1:0] done_cnt,
    output logic          busy
);
    // Count issues and completions; clear at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            iss_cnt  <= '0;
            done_cnt <= '0;
        end else begin
            if (issue) iss_cnt  <= iss_cnt + 1'b1;
            if (done)  done_cnt <= done_cnt + 1'b1;
        end
    end

    // Busy while a command is outstanding.
    always_comb busy = (iss_cnt != done_cnt);

    p_single_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !busy);
    p_done_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |-> busy);
endmodule

// File: rtl/brk_stage_seq.sv
// Brick-level stage sequencer. Forms brick parameters, then issues fetch,
// compute and store commands with ping-pong hazards on input sections and
// output caches. Assumes the count and origin words stay fixed during a run.
module brk_stage_seq
    import brk_seq_pkg::*;
#(
    parameter int BW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_origin,
    output logic [DATA_W-1:0] fetch_size,
    output logic              fetch_sect,
    input  logic              fetch_done,
    output logic              comp_valid,
    input  logic              comp_ready,
    output logic [BW-1:0]     comp_brick,
    output logic [DATA_W-1:0] comp_angle,
    output logic [DATA_W-1:0] comp_tag,
    output logic              comp_sect,
    output logic              comp_ocache,
    input  logic              comp_done,
    output logic              store_valid,
    input  logic              store_ready,
    output logic [DATA_W-1:0] store_origin,
    output logic [DATA_W-1:0] store_size,
    output logic              store_ocache,
    input  logic              store_done,
    output logic              run_busy,
    output logic              run_done,
    output logic [3:0]        stage_busy,
    output logic [BW-1:0]     bricks_stored
);
    localparam logic [BW-1:0] LEAD_LIM = BW'(LEAD_MAX);

    logic          start_pulse, stop_q;
    cfg_t          cfg;
    logic          run_q, done_q, mb_q;
    logic [BW-1:0] p_cnt;
    logic [BW-1:0] fi, fd, ci, cd, si, sd;
    logic          f_busy, c_busy, s_busy;
    logic          start_go, load, finish, f_fire, c_fire, s_fire;
    logic [BW-1:0] f_lead, c_lead;

    brk_param_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .start_pulse(start_pulse), .stop_q(stop_q), .cfg(cfg)
    );

    brk_stage_trk #(.BW(BW)) u_fetch_trk (
        .clk(clk), .rst_n(rst_n), .clr(start_go), .issue(f_fire), .done(fetch_done),
        .iss_cnt(fi), .done_cnt(fd), .busy(f_busy)
    );
    brk_stage_trk #(.BW(BW)) u_comp_trk (
        .clk(clk), .rst_n(rst_n), .clr(start_go), .issue(c_fire), .done(comp_done),
        .iss_cnt(ci), .done_cnt(cd), .busy(c_busy)
    );
    brk_stage_trk #(.BW(BW)) u_store_trk (
        .clk(clk), .rst_n(rst_n), .clr(start_go), .issue(s_fire), .done(store_done),
        .iss_cnt(si), .done_cnt(sd), .busy(s_busy)
    );

    // Hazard distances: bricks holding an input section / output cache.
    always_comb begin
        f_lead = fi - cd;
        c_lead = ci - sd;
    end

    // Issue rules for the three command channels.
    always_comb begin
        start_go    = start_pulse && !run_q;
        load        = run_q && !stop_q && !mb_q && (DATA_W'(p_cnt) != cfg.count);
        finish      = run_q && !mb_q && (sd == p_cnt) && (stop_q || DATA_W'(p_cnt) == cfg.count);
        fetch_valid = mb_q && !f_busy && (f_lead < LEAD_LIM);
        comp_valid  = (ci != fd) && !c_busy && (c_lead < LEAD_LIM);
        store_valid = (si != cd) && !s_busy;
        f_fire      = fetch_valid && fetch_ready;
        c_fire      = comp_valid && comp_ready;
        s_fire      = store_valid && store_ready;
    end

    // Command payloads derived from each stage's next brick index.
    always_comb begin
        fetch_origin = cfg.in_base + DATA_W'(fi) * cfg.in_step;
        fetch_size   = cfg.in_size;
        fetch_sect   = fi[0];
        comp_brick   = ci;
        comp_angle   = cfg.angle;
        comp_tag     = cfg.tag;
        comp_sect    = ci[0];
        comp_ocache  = ci[0];
        store_origin = cfg.out_base + DATA_W'(si) * cfg.out_step;
        store_size   = cfg.out_size;
        store_ocache = si[0];
    end

    // Run control, parameter mailbox and brick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            mb_q   <= 1'b0;
            p_cnt  <= '0;
        end else if (start_go) begin
            run_q  <= 1'b1;
            done_q <= 1'b0;
            mb_q   <= 1'b0;
            p_cnt  <= '0;
        end else begin
            if (finish) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
            if (load) begin
                mb_q  <= 1'b1;
                p_cnt <= p_cnt + 1'b1;
            end else if (f_fire) begin
                mb_q <= 1'b0;
            end
        end
    end

    // Status outputs.
    always_comb begin
        run_busy      = run_q;
        run_done      = done_q;
        stage_busy    = {s_busy, c_busy, f_busy, mb_q};
        bricks_stored = sd;
    end

    p_sections_r5: assert property (@(posedge clk) disable iff (!rst_n)
        f_lead <= LEAD_LIM);
    p_ocache_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_lead <= LEAD_LIM);
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ci <= fd) && (si <= cd));
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (stage_busy == 4'b0000));
    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && stop_q) |=> $stable(p_cnt));
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (p_cnt >= $past(p_cnt)));
endmodule

// File: tb/brk_stage_seq_tb.sv
// Bench: behavioural reference model (integer counters) compared each cycle,
// plus random-latency responders for the three subsystems.
module brk_stage_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  rdy_v = '0, done_v = '0;
    logic        fetch_valid, comp_valid, store_valid, fetch_sect, comp_sect, comp_ocache, store_ocache;
    logic [31:0] fetch_origin, fetch_size, comp_angle, comp_tag, store_origin, store_size;
    logic [15:0] comp_brick, bricks_stored;
    logic        run_busy, run_done;
    logic [3:0]  stage_busy;

    always #2.5 clk = ~clk;

    brk_stage_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .fetch_valid(fetch_valid), .fetch_ready(rdy_v[0]), .fetch_origin(fetch_origin),
        .fetch_size(fetch_size), .fetch_sect(fetch_sect), .fetch_done(done_v[0]),
        .comp_valid(comp_valid), .comp_ready(rdy_v[1]), .comp_brick(comp_brick),
        .comp_angle(comp_angle), .comp_tag(comp_tag), .comp_sect(comp_sect),
        .comp_ocache(comp_ocache), .comp_done(done_v[1]),
        .store_valid(store_valid), .store_ready(rdy_v[2]), .store_origin(store_origin),
        .store_size(store_size), .store_ocache(store_ocache), .store_done(done_v[2]),
        .run_busy(run_busy), .run_done(run_done), .stage_busy(stage_busy),
        .bricks_stored(bricks_stored)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_reg [0:9];
    int m_run, m_done, m_stop, m_mb, m_p, m_fi, m_fd, m_ci, m_cd, m_si, m_sd;

    function automatic bit e_fv();
        return m_mb != 0 && (m_fi - m_cd) < 2 && m_fi == m_fd;
    endfunction
    function automatic bit e_cv();
        return m_ci < m_fd && m_ci == m_cd && (m_ci - m_sd) < 2;
    endfunction
    function automatic bit e_sv();
        return m_si < m_cd && m_si == m_sd;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 10; i++) m_reg[i] = '0;
            {m_run, m_done, m_stop, m_mb, m_p} = '0;
            {m_fi, m_fd, m_ci, m_cd, m_si, m_sd} = '0;
        end else begin
            automatic int  cnt   = int'(m_reg[1]);
            automatic bit  fv    = e_fv(), cv = e_cv(), sv = e_sv();
            automatic bit  start = reg_we && reg_addr == 0 && reg_wdata[0] && m_run == 0;
            automatic bit  load  = m_run != 0 && m_stop == 0 && m_mb == 0 && m_p != cnt;
            automatic bit  fin   = m_run != 0 && m_mb == 0 && m_sd == m_p && (m_stop != 0 || m_p == cnt);
            if (reg_we) begin
                if (reg_addr == 0) m_stop = int'(reg_wdata[1]);
                else if (reg_addr < 10) m_reg[reg_addr] = reg_wdata;
            end
            if (start) begin
                m_run = 1; m_done = 0; m_p = 0; m_mb = 0;
                {m_fi, m_fd, m_ci, m_cd, m_si, m_sd} = '0;
            end else begin
                if (fin) begin m_run = 0; m_done = 1; end
                if (load) begin m_mb = 1; m_p++; end
                if (fv && rdy_v[0]) begin m_mb = 0; m_fi++; end
                if (cv && rdy_v[1]) m_ci++;
                if (sv && rdy_v[2]) m_si++;
                m_fd += int'(done_v[0]);
                m_cd += int'(done_v[1]);
                m_sd += int'(done_v[2]);
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    bit saw_overlap = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit ok = 1;
            automatic logic [31:0] e_fo = m_reg[2] + 32'(m_fi) * m_reg[3];
            automatic logic [31:0] e_so = m_reg[5] + 32'(m_si) * m_reg[6];
            automatic logic [3:0]  e_bz = {m_si != m_sd, m_ci != m_cd, m_fi != m_fd, m_mb != 0};
            n_chk++;
            if (fetch_valid !== e_fv()) begin ok = 0; $display("FAIL R5 fetch_valid: actual=%0b expected=%0b", fetch_valid, e_fv()); end
            if (comp_valid !== e_cv()) begin ok = 0; $display("FAIL R6 comp_valid: actual=%0b expected=%0b", comp_valid, e_cv()); end
            if (store_valid !== e_sv()) begin ok = 0; $display("FAIL R3 store_valid: actual=%0b expected=%0b", store_valid, e_sv()); end
            if (e_fv() && ({fetch_origin, fetch_size, 31'd0, fetch_sect} !== {e_fo, m_reg[4], 31'd0, 1'(m_fi)})) begin
                ok = 0; $display("FAIL R2 fetch payload: actual=%0h/%0h expected=%0h/%0h", fetch_origin, fetch_size, e_fo, m_reg[4]); end
            if (e_cv() && ({comp_brick, comp_angle, comp_tag, comp_sect, comp_ocache} !== {16'(m_ci), m_reg[8], m_reg[9], 1'(m_ci), 1'(m_ci)})) begin
                ok = 0; $display("FAIL R2 compute payload: actual=%0h expected=%0h", comp_brick, m_ci); end
            if (e_sv() && ({store_origin, store_size, store_ocache} !== {e_so, m_reg[7], 1'(m_si)})) begin
                ok = 0; $display("FAIL R6 store payload: actual=%0h expected=%0h", store_origin, e_so); end
            if (run_done !== 1'(m_done) || run_busy !== 1'(m_run)) begin
                ok = 0; $display("FAIL R8 run flags: actual=%0b%0b expected=%0b%0b", run_busy, run_done, m_run, m_done); end
            if (stage_busy !== e_bz || bricks_stored !== 16'(m_sd)) begin
                ok = 0; $display("FAIL R10 status: actual=%0h/%0d expected=%0h/%0d", stage_busy, bricks_stored, e_bz, m_sd); end
            if (!ok) n_bad++;
            if ($countones(stage_busy) >= 2) saw_overlap = 1;
        end
    end

    // ---------------- subsystem responders ----------------
    int lat [3] = '{3, 3, 3};
    int out_q [3], tmr [3], nacc [3], ndone [3];
    bit fire_q [3];
    int max_in = 0, max_out = 0;
    bit bad_r4 = 0, bad_r3 = 0;
    always @(negedge clk) begin
        automatic logic [2:0] vld = {store_valid, comp_valid, fetch_valid};
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                out_q[k] = 0; tmr[k] = 0; nacc[k] = 0; ndone[k] = 0; fire_q[k] = 0;
            end
            rdy_v = '0; done_v = '0;
        end else begin
            for (int k = 0; k < 3; k++) begin
                done_v[k] = 1'b0;
                if (fire_q[k]) begin
                    if (out_q[k] != 0) bad_r4 = 1;
                    if (k > 0 && nacc[k] >= ndone[k-1]) bad_r3 = 1;
                    nacc[k]++; out_q[k] = 1; tmr[k] = 1 + int'($urandom % lat[k]);
                end else if (out_q[k] != 0) begin
                    tmr[k]--;
                    if (tmr[k] == 0) begin done_v[k] = 1'b1; out_q[k] = 0; ndone[k]++; end
                end
                rdy_v[k] = ($urandom % 4) != 0;
                fire_q[k] = vld[k] && rdy_v[k];
            end
            if (nacc[0] - ndone[1] > max_in) max_in = nacc[0] - ndone[1];
            if (nacc[1] - ndone[2] > max_out) max_out = nacc[1] - ndone[2];
        end
    end

    // Watchdog: counts as a failed check, still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog: actual=running expected=finished");
            summary();
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!run_done && t < 5000) begin @(negedge clk); t++; end
        check(run_done === 1'b1, "R8 run finishes", 64'(run_done), 64'd1);
    endtask

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({fetch_valid, comp_valid, store_valid, run_done, stage_busy, bricks_stored} === '0,
              "R1 reset state", 64'({fetch_valid, comp_valid, store_valid, run_done, stage_busy, bricks_stored}), 64'd0);

        wr(1, 5); wr(2, 32'h1000); wr(3, 32'h200); wr(4, 32'h40); wr(5, 32'h8000);
        wr(6, 32'h100); wr(7, 32'h80); wr(8, 32'h2d); wr(9, 32'hcafe);
        wr(12, 32'hdead); // R2: out-of-range address ignored (model ignores too)
        saw_overlap = 0;
        wr(0, 1);
        wait_done();
        check(bricks_stored == 16'd5, "R8 five bricks stored", 64'(bricks_stored), 64'd5);
        check(saw_overlap, "R7 stages overlap", 64'(saw_overlap), 64'd1);

        // R8: zero bricks
        wr(1, 0);
        snap = nacc[0];
        wr(0, 1);
        wait_done();
        check(nacc[0] == snap, "R8 zero count issues no fetch", 64'(nacc[0]), 64'(snap));

        // R5: slow compute fills both input sections
        lat = '{1, 14, 1}; max_in = 0; wr(1, 8); wr(0, 1);
        wait_done();
        check(max_in == 2, "R5 section bound reached", 64'(max_in), 64'd2);

        // R6: slow store fills both output caches
        lat = '{1, 1, 14}; max_out = 0; wr(0, 1);
        wait_done();
        check(max_out == 2, "R6 output cache bound reached", 64'(max_out), 64'd2);
        check(bricks_stored == 16'd8, "R10 stored count", 64'(bricks_stored), 64'd8);

        // R9: stop drains in-flight bricks
        lat = '{3, 3, 3}; wr(1, 30); wr(0, 1);
        repeat (25) @(negedge clk);
        wr(0, 2);
        wait_done();
        check(bricks_stored == 16'(m_p), "R9 all loaded bricks stored", 64'(bricks_stored), 64'(m_p));
        check(bricks_stored > 0 && bricks_stored < 30, "R9 run cut short", 64'(bricks_stored), 64'd30);

        // R11: start during a run is ignored
        wr(1, 6); wr(0, 1);
        repeat (12) @(negedge clk);
        wr(0, 1);
        wait_done();
        check(bricks_stored == 16'd6, "R11 run not restarted", 64'(bricks_stored), 64'd6);

        check(!bad_r4, "R4 single outstanding command", 64'(bad_r4), 64'd0);
        check(!bad_r3, "R3 stage order", 64'(bad_r3), 64'd0);
        summary();
    end
endmodule